// File: doc/BRIEF.md
# Guest Control Register Virtualization Unit

This block sits next to a core's two main control registers (the machine-control word CR0 and the feature-enable word CR4). It decides what privileged control-register instructions do while the core runs a guest. Each command arrives in one cycle with an opcode, a 4-bit machine-status operand and a guest-mode flag. One cycle later the unit returns a registered response. The response holds a read result, the new CR0 value with a write strobe, the new NMI-blocked flag with its own strobe, and a two-bit outcome: completed, general-protection fault, or exit to the hypervisor.

The real register contents and the NMI-blocked flag are owned by the core and presented as inputs. The hypervisor provides the configuration inputs: a guest/host ownership mask and a read shadow for each register, two CR0 legality masks (bits that must read 1 and bits that must read 0), and a control that keeps interrupt-return from releasing NMI blocking. Decoding of instructions, the exit sequence itself and moves into the control registers are handled elsewhere.

Top module: `gcv_unit`

## Requirements
- R1: Each command accepted with `cmd_valid` high gives `rsp_valid` high on the following cycle only. After reset every response output is zero. Opcodes are 0 clear-TS, 1 load-status-word, 2 read CR0, 3 read CR4, 4 interrupt-return. Outcome codes are 00 completed, 01 fault, 10 exit.
- R2: In guest mode, read CR0 returns, in each bit position, the shadow bit where the CR0 mask bit is 1 and the real CR0 bit where it is 0.
- R3: In guest mode, read CR4 applies the same per-bit choice using the CR4 mask and the CR4 shadow.
- R4: Outside guest mode, reads return the real register. Outside guest mode, clear-TS clears CR0 bit 3 with a write and outcome 00, whatever the masks, the shadow or the legality inputs hold.
- R5: In guest mode with CR0 mask bit 3 at 0 and must-be-1 bit 3 at 0, clear-TS writes CR0 with bit 3 cleared and outcome 00. Shadow bit 3 plays no part.
- R6: In guest mode with CR0 mask bit 3 at 0 and must-be-1 bit 3 at 1, clear-TS gives outcome 01.
- R7: In guest mode with CR0 mask bit 3 at 1 and shadow bit 3 at 0, clear-TS gives outcome 00 with no CR0 write.
- R8: In guest mode with CR0 mask bit 3 at 1 and shadow bit 3 at 1, clear-TS gives outcome 10.
- R9: Load-status-word changes only CR0 bits 0 to 3. It can set bit 0 but never clear it.
- R10: In guest mode, load-status-word keeps the current value of every CR0 bit 0 to 3 whose mask bit is 1. It exits (outcome 10) when any such bit in 1 to 3 differs from its shadow bit, or when mask bit 0 is 1, the operand sets bit 0 and shadow bit 0 is 0.
- R11: In guest mode, a non-exiting load-status-word whose resulting CR0 has a 1 where must-be-0 is 1, or a 0 where must-be-1 is 1, gives outcome 01. Outside guest mode no such check is made.
- R12: Interrupt-return gives outcome 00. It clears the NMI-blocked flag with a strobe, except in guest mode with NMI exiting set, where the flag is left as it was and there is no strobe.
- R13: On outcome 01 or 10, neither strobe is raised and `rsp_cr0` equals the CR0 input of the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode |
| cmd_msw | input | 4 | Load-status-word operand |
| cmd_guest | input | 1 | Command issued by guest |
| cr0_cur | input | W | Real CR0 |
| cr4_cur | input | W | Real CR4 |
| cr0_mask | input | W | CR0 ownership mask (1 = hypervisor owned) |
| cr0_shadow | input | W | CR0 read shadow |
| cr4_mask | input | W | CR4 ownership mask |
| cr4_shadow | input | W | CR4 read shadow |
| cr0_must1 | input | W | CR0 bits that must be 1 |
| cr0_must0 | input | W | CR0 bits that must be 0 |
| nmi_exit_ctl | input | 1 | NMI exiting control |
| nmi_blk_cur | input | 1 | Current NMI-blocked flag |
| rsp_valid | output | 1 | Response present |
| rsp_outcome | output | 2 | 00 completed, 01 fault, 10 exit |
| rsp_rdata | output | W | Read result (zero for non-reads) |
| rsp_cr0 | output | W | New CR0 value |
| rsp_cr0_wr | output | 1 | CR0 write strobe |
| rsp_nmi_blk | output | 1 | New NMI-blocked flag |
| rsp_nmi_wr | output | 1 | NMI flag write strobe |

## Verification
Reads are tried with an all-zero mask, an all-ones mask, a split half-word mask with distinct real and shadow values, and again outside guest mode. These show whether a mask is ignored, applied the wrong way round or applied in the wrong mode. Clear-TS is driven through all four combinations of mask bit, shadow bit and must-be-1 bit, so that each of the three outcomes can be told apart from a silent completion. Load-status-word stimulus separates keeping a masked bit, the sticky bit 0, a shadow mismatch exit, and faults from either legality mask, including the host-mode case that must skip them. Interrupt-return is run with the NMI control both ways and in both modes.

// File: rtl/gcv_pkg.sv
package gcv_pkg;
  typedef enum logic [2:0] {
    OP_CLTS   = 3'd0,
    OP_LMSW   = 3'd1,
    OP_RD_CR0 = 3'd2,
    OP_RD_CR4 = 3'd3,
    OP_IRET   = 3'd4
  } gcv_op_e;

  typedef enum logic [1:0] {
    OC_DONE  = 2'b00,
    OC_FAULT = 2'b01,
    OC_EXIT  = 2'b10
  } gcv_oc_e;

  localparam int TS_POS  = 3;
  localparam int MSW_LEN = 4;
endpackage

// File: rtl/gcv_read_merge.sv
module gcv_read_merge #(
  parameter int W = 32
) (
  input  logic         guest,
  input  logic         sel_cr4,
  input  logic [W-1:0] cr0_cur,
  input  logic [W-1:0] cr0_mask,
  input  logic [W-1:0] cr0_shadow,
  input  logic [W-1:0] cr4_cur,
  input  logic [W-1:0] cr4_mask,
  input  logic [W-1:0] cr4_shadow,
  output logic [W-1:0] rdata
);
  // owned bits come from the shadow, the rest from the real register
  function automatic logic [W-1:0] blend(input logic [W-1:0] real_v,
                                         input logic [W-1:0] own,
                                         input logic [W-1:0] shad);
    return (real_v & ~own) | (shad & own);
  endfunction

  logic [W-1:0] view0, view4;
  assign view0 = guest ? blend(cr0_cur, cr0_mask, cr0_shadow) : cr0_cur;
  assign view4 = guest ? blend(cr4_cur, cr4_mask, cr4_shadow) : cr4_cur;
  assign rdata = sel_cr4 ? view4 : view0;
endmodule

// File: rtl/gcv_clts.sv
module gcv_clts
  import gcv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         guest,
  input  logic [W-1:0] cr0_cur,
  input  logic         own_ts,
  input  logic         shadow_ts,
  input  logic         must1_ts,
  output gcv_oc_e      outcome,
  output logic [W-1:0] cr0_new,
  output logic         wr
);
  logic [W-1:0] ts_bit;
  assign ts_bit = W'(1) << TS_POS;

  always_comb begin
    outcome = OC_DONE;
    cr0_new = cr0_cur;
    wr      = 1'b0;
    if (!guest || (!own_ts && !must1_ts)) begin
      cr0_new = cr0_cur & ~ts_bit;
      wr      = 1'b1;
    end else if (!own_ts) begin
      outcome = OC_FAULT;
    end else if (shadow_ts) begin
      outcome = OC_EXIT;
    end
  end
endmodule

// File: rtl/gcv_lmsw.sv
module gcv_lmsw
  import gcv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic               guest,
  input  logic [MSW_LEN-1:0] src,
  input  logic [W-1:0]       cr0_cur,
  input  logic [W-1:0]       cr0_mask,
  input  logic [W-1:0]       cr0_shadow,
  input  logic [W-1:0]       cr0_must1,
  input  logic [W-1:0]       cr0_must0,
  output gcv_oc_e            outcome,
  output logic [W-1:0]       cr0_new,
  output logic               wr
);
  logic [MSW_LEN-1:0] low_new;
  logic               want_exit;
  logic [W-1:0]       cand;
  logic               illegal;

  always_comb begin
    want_exit = 1'b0;
    for (int k = 0; k < MSW_LEN; k++) begin
      if (guest && cr0_mask[k]) begin
        low_new[k] = cr0_cur[k];
        if (k == 0) want_exit = want_exit | (src[0] & ~cr0_shadow[0]);
        else        want_exit = want_exit | (src[k] ^ cr0_shadow[k]);
      end else if (k == 0) begin
        low_new[k] = cr0_cur[0] | src[0];
      end else begin
        low_new[k] = src[k];
      end
    end
  end

  assign cand    = {cr0_cur[W-1:MSW_LEN], low_new};
  assign illegal = guest && (((cand & cr0_must0) | (~cand & cr0_must1)) != '0);

  always_comb begin
    outcome = OC_DONE;
    cr0_new = cr0_cur;
    wr      = 1'b0;
    if (want_exit)    outcome = OC_EXIT;
    else if (illegal) outcome = OC_FAULT;
    else begin
      cr0_new = cand;
      wr      = 1'b1;
    end
  end
endmodule

// File: rtl/gcv_unit.sv
module gcv_unit
  import gcv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [MSW_LEN-1:0] cmd_msw,
  input  logic               cmd_guest,
  input  logic [W-1:0]       cr0_cur,
  input  logic [W-1:0]       cr4_cur,
  input  logic [W-1:0]       cr0_mask,
  input  logic [W-1:0]       cr0_shadow,
  input  logic [W-1:0]       cr4_mask,
  input  logic [W-1:0]       cr4_shadow,
  input  logic [W-1:0]       cr0_must1,
  input  logic [W-1:0]       cr0_must0,
  input  logic               nmi_exit_ctl,
  input  logic               nmi_blk_cur,
  output logic               rsp_valid,
  output logic [1:0]         rsp_outcome,
  output logic [W-1:0]       rsp_rdata,
  output logic [W-1:0]       rsp_cr0,
  output logic               rsp_cr0_wr,
  output logic               rsp_nmi_blk,
  output logic               rsp_nmi_wr
);
  gcv_op_e      op;
  logic [W-1:0] rd_val, clts_cr0, lmsw_cr0;
  gcv_oc_e      clts_oc, lmsw_oc;
  logic         clts_wr, lmsw_wr;
  assign op = gcv_op_e'(cmd_op);

  gcv_read_merge #(.W(W)) u_rd (
    .guest(cmd_guest), .sel_cr4(op == OP_RD_CR4),
    .cr0_cur(cr0_cur), .cr0_mask(cr0_mask), .cr0_shadow(cr0_shadow),
    .cr4_cur(cr4_cur), .cr4_mask(cr4_mask), .cr4_shadow(cr4_shadow),
    .rdata(rd_val));

  gcv_clts #(.W(W)) u_clts (
    .guest(cmd_guest), .cr0_cur(cr0_cur), .own_ts(cr0_mask[TS_POS]),
    .shadow_ts(cr0_shadow[TS_POS]), .must1_ts(cr0_must1[TS_POS]),
    .outcome(clts_oc), .cr0_new(clts_cr0), .wr(clts_wr));

  gcv_lmsw #(.W(W)) u_lmsw (
    .guest(cmd_guest), .src(cmd_msw), .cr0_cur(cr0_cur), .cr0_mask(cr0_mask),
    .cr0_shadow(cr0_shadow), .cr0_must1(cr0_must1), .cr0_must0(cr0_must0),
    .outcome(lmsw_oc), .cr0_new(lmsw_cr0), .wr(lmsw_wr));

  gcv_oc_e      nx_oc;
  logic [W-1:0] nx_rd, nx_cr0;
  logic         nx_cr0_wr, nx_nmi, nx_nmi_wr;

  always_comb begin
    nx_oc     = OC_DONE;
    nx_rd     = '0;
    nx_cr0    = cr0_cur;
    nx_cr0_wr = 1'b0;
    nx_nmi    = nmi_blk_cur;
    nx_nmi_wr = 1'b0;
    case (op)
      OP_RD_CR0, OP_RD_CR4: nx_rd = rd_val;
      OP_CLTS: begin
        nx_oc = clts_oc; nx_cr0 = clts_cr0; nx_cr0_wr = clts_wr;
      end
      OP_LMSW: begin
        nx_oc = lmsw_oc; nx_cr0 = lmsw_cr0; nx_cr0_wr = lmsw_wr;
      end
      OP_IRET: begin
        if (!(cmd_guest && nmi_exit_ctl)) begin
          nx_nmi    = 1'b0;
          nx_nmi_wr = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_outcome <= 2'b00;
      rsp_rdata   <= '0;
      rsp_cr0     <= '0;
      rsp_cr0_wr  <= 1'b0;
      rsp_nmi_blk <= 1'b0;
      rsp_nmi_wr  <= 1'b0;
    end else begin
      rsp_valid   <= cmd_valid;
      rsp_outcome <= cmd_valid ? nx_oc : 2'b00;
      rsp_rdata   <= cmd_valid ? nx_rd : '0;
      rsp_cr0     <= cmd_valid ? nx_cr0 : '0;
      rsp_cr0_wr  <= cmd_valid & nx_cr0_wr;
      rsp_nmi_blk <= cmd_valid ? nx_nmi : 1'b0;
      rsp_nmi_wr  <= cmd_valid & nx_nmi_wr;
    end
  end

  // R1: an undefined outcome code never appears
  a_r1_outcome_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_outcome != 2'b11);
  // R2: fully owned CR0 reads give the shadow
  a_r2_full_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_guest && op == OP_RD_CR0 && &cr0_mask)
      |=> rsp_rdata == $past(cr0_shadow));
  // R4: host reads of CR4 ignore the shadow
  a_r4_host_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_guest && op == OP_RD_CR4) |=> rsp_rdata == $past(cr4_cur));
  // R7: owned TS with clear shadow completes silently
  a_r7_clts_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_guest && op == OP_CLTS && cr0_mask[TS_POS] && !cr0_shadow[TS_POS])
      |=> (rsp_outcome == OC_DONE && !rsp_cr0_wr));
  // R8: owned TS with set shadow exits
  a_r8_clts_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_guest && op == OP_CLTS && cr0_mask[TS_POS] && cr0_shadow[TS_POS])
      |=> rsp_outcome == OC_EXIT);
  // R9: load-status-word never clears bit 0
  a_r9_pe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_LMSW && cr0_cur[0]) |=> (!rsp_cr0_wr || rsp_cr0[0]));
  // R12: NMI exiting keeps the guest flag
  a_r12_iret_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_guest && op == OP_IRET && nmi_exit_ctl) |=> !rsp_nmi_wr);
  // R13: aborted commands write nothing
  a_r13_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_outcome != 2'b00)
      |-> (!rsp_cr0_wr && !rsp_nmi_wr && rsp_cr0 == $past(cr0_cur)));
endmodule

// File: tb/gcv_unit_bench.sv
`timescale 1ns/1ps
module gcv_unit_bench;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_guest = 0, nmi_exit_ctl = 0, nmi_blk_cur = 0;
  logic [2:0] cmd_op = 0;
  logic [3:0] cmd_msw = 0;
  logic [W-1:0] cr0_cur = 0, cr4_cur = 0, cr0_mask = 0, cr0_shadow = 0;
  logic [W-1:0] cr4_mask = 0, cr4_shadow = 0, cr0_must1 = 0, cr0_must0 = 0;
  logic rsp_valid, rsp_cr0_wr, rsp_nmi_blk, rsp_nmi_wr;
  logic [1:0] rsp_outcome;
  logic [W-1:0] rsp_rdata, rsp_cr0;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gcv_unit #(.W(W)) u_gcv_unit (.*);

  function automatic logic [W-1:0] pick(input logic [W-1:0] r, input logic [W-1:0] m,
                                        input logic [W-1:0] s);
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = m[i] ? s[i] : r[i];
    return v;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [3:0] msw, input logic g);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_msw = msw; cmd_guest = g;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 valid at reset", W'(rsp_valid), 0);
    chk("R1 cr0 at reset", rsp_cr0, 0);
    chk("R1 outcome at reset", W'(rsp_outcome), 0);
  endtask

  task automatic t_reads;
    cr0_cur = 32'h1234_5678; cr0_shadow = 32'hABCD_EF01;
    cr4_cur = 32'h0000_3F0F; cr4_shadow = 32'hFFFF_0000;
    cr0_mask = 0; issue(2, 0, 1);
    chk("R1 response valid", W'(rsp_valid), 1);
    chk("R2 mask zero", rsp_rdata, cr0_cur);
    @(negedge clk); chk("R1 single cycle", W'(rsp_valid), 0);
    cr0_mask = '1; issue(2, 0, 1); chk("R2 mask ones", rsp_rdata, cr0_shadow);
    cr0_mask = 32'hFFFF_0000; issue(2, 0, 1);
    chk("R2 split mask", rsp_rdata, pick(cr0_cur, cr0_mask, cr0_shadow));
    cr4_mask = 32'h0F0F_0F0F; issue(3, 0, 1);
    chk("R3 cr4 merge", rsp_rdata, pick(cr4_cur, cr4_mask, cr4_shadow));
    issue(3, 0, 0); chk("R4 host cr4", rsp_rdata, cr4_cur);
    issue(2, 0, 0); chk("R4 host cr0", rsp_rdata, cr0_cur);
  endtask

  task automatic t_clts;
    cr0_cur = 32'h8000_0009; cr0_must1 = 0;
    cr0_mask = 0; cr0_shadow = 32'h8;
    issue(0, 0, 1);
    chk("R5 clear ts", rsp_cr0, 32'h8000_0001);
    chk("R5 write", W'(rsp_cr0_wr), 1); chk("R5 outcome", W'(rsp_outcome), 0);
    cr0_must1 = 32'h8; issue(0, 0, 1);
    chk("R6 fault", W'(rsp_outcome), 1); chk("R13 no write on fault", W'(rsp_cr0_wr), 0);
    chk("R13 cr0 kept", rsp_cr0, cr0_cur);
    cr0_mask = 32'h8; cr0_shadow = 0; issue(0, 0, 1);
    chk("R7 outcome", W'(rsp_outcome), 0); chk("R7 no write", W'(rsp_cr0_wr), 0);
    cr0_shadow = 32'h8; issue(0, 0, 1);
    chk("R8 exit", W'(rsp_outcome), 2); chk("R13 no write on exit", W'(rsp_cr0_wr), 0);
    issue(0, 0, 0);
    chk("R4 host clts", rsp_cr0, 32'h8000_0001); chk("R4 host outcome", W'(rsp_outcome), 0);
    cr0_must1 = 0;
  endtask

  task automatic t_lmsw;
    cr0_mask = 0; cr0_shadow = 0; cr0_must0 = 0; cr0_must1 = 0;
    cr0_cur = 32'h8000_0011; issue(1, 4'hE, 1);
    chk("R9 low nibble", rsp_cr0, 32'h8000_001F); chk("R9 write", W'(rsp_cr0_wr), 1);
    cr0_cur = 32'h8000_0001; issue(1, 4'h0, 1);
    chk("R9 bit0 sticky", rsp_cr0, 32'h8000_0001);
    cr0_cur = 0; cr0_mask = 32'h4; cr0_shadow = 32'h4; issue(1, 4'hE, 1);
    chk("R10 owned bit kept", rsp_cr0, 32'h0000_000A);
    cr0_shadow = 0; issue(1, 4'h4, 1);
    chk("R10 mismatch exit", W'(rsp_outcome), 2); chk("R13 exit keeps cr0", rsp_cr0, 0);
    cr0_mask = 0; cr0_must0 = 32'h8; issue(1, 4'h8, 1);
    chk("R11 must0 fault", W'(rsp_outcome), 1);
    issue(1, 4'h8, 0);
    chk("R11 host no check", W'(rsp_outcome), 0); chk("R11 host value", rsp_cr0, 32'h8);
    cr0_must0 = 0; cr0_must1 = 32'h2; cr0_cur = 32'h2; issue(1, 4'h0, 1);
    chk("R11 must1 fault", W'(rsp_outcome), 1);
    cr0_must1 = 0;
  endtask

  task automatic t_iret;
    nmi_blk_cur = 1; nmi_exit_ctl = 0; issue(4, 0, 1);
    chk("R12 unblock", W'(rsp_nmi_blk), 0); chk("R12 strobe", W'(rsp_nmi_wr), 1);
    nmi_exit_ctl = 1; issue(4, 0, 1);
    chk("R12 hold flag", W'(rsp_nmi_blk), 1); chk("R12 no strobe", W'(rsp_nmi_wr), 0);
    chk("R12 outcome", W'(rsp_outcome), 0);
    issue(4, 0, 0); chk("R12 host unblock", W'(rsp_nmi_wr), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_reads; t_clts; t_lmsw; t_iret;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule